// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that gives software two chances before the system is reset. It keeps a free-running system counter and a compare value. Each refresh, with the watchdog enabled, loads the compare value with the current count plus a programmable 48-bit offset. If the counter reaches the compare value without a refresh, the first stage fires. It sets a first-stage status flag, raises a level interrupt and re-arms the compare one offset further on. If that second window also runs out, the second stage sets a second-stage flag and emits a one-cycle reset pulse. On the cycle after the pulse, the watchdog's own registers return to their reset values.

Software reaches the block through two register frames, selected by `bus_frame`, on a simple single-cycle access port. Read data is combinational in the same cycle. The refresh frame (`bus_frame`=0) holds only the refresh register and an identification word. The control frame (`bus_frame`=1) holds the control/status word, the two offset words, the two compare words (read-only) and the identification word. Writes to the control/status word or to either offset word also act as a refresh. A write that lands in the same cycle as an expiry takes priority over the expiry.

Top module: `wdt2_top`

## Requirements
- R1: The offset is 48 bits. Control-frame offset 0x008 holds bits 31:0 (all 32 bits kept). Offset 0x00C holds bits 47:32 in its bits 15:0; a write keeps only those 16 bits, and a read returns zero above bit 15.
- R2: A refresh while enabled loads the compare value with counter + offset. The compare value reads at control-frame 0x010 (low word) and 0x014 (high word). The interrupt rises on the clock edge that lies exactly offset edges after the refresh write edge.
- R3: A write of any data to refresh-frame offset 0x000 clears both status flags, drops the interrupt and performs a refresh.
- R4: A read of refresh-frame offset 0x000 returns 0 and changes no state.
- R5: Control-frame offset 0x000 is control/status: bit 0 enable, bit 1 first-stage flag, bit 2 second-stage flag. A write keeps only bit 0 as the enable, clears both flags, drops the interrupt and performs a refresh.
- R6: A write to either offset word clears both flags, drops the interrupt and performs a refresh using the new offset.
- R7: On the first expiry the first-stage flag sets, the interrupt goes high and stays high, and the compare value becomes the old compare value + offset.
- R8: On a second expiry with no refresh in between, the second-stage flag sets and `wd_rst` is high for exactly one cycle. On the next edge the enable, flags, interrupt, offset and compare all return to 0, and the counter keeps running.
- R9: Only accesses with `bus_be`=4'b1111 and address bits 1:0 equal to 0 take effect. Other accesses, and accesses to undefined offsets, change nothing and read 0.
- R10: Offset 0xFCC in both frames reads the identification value `ID_VALUE`.
- R11: While the enable is clear, no expiry takes place, so neither `wd_irq` nor `wd_rst` asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_req | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = refresh frame, 1 = control frame |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| wd_irq | output | 1 | First-stage interrupt, level |
| wd_rst | output | 1 | Second-stage reset, one-cycle pulse |

## Verification
The bench builds the block with the default 64-bit counter and 48-bit offset, and sets `CNT_INIT` to 16 counts below the 32-bit boundary. With that reset value, the counter's carry into its upper word, and a compare value whose high word reads 1, occur within the first few dozen cycles. A small offset of 20 keeps both expiry stages and their exact edge timing short enough to check cycle by cycle.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] A_REFRESH = 12'h000;
  localparam logic [REG_AW-1:0] A_CTRL    = 12'h000;
  localparam logic [REG_AW-1:0] A_OFF_LO  = 12'h008;
  localparam logic [REG_AW-1:0] A_OFF_HI  = 12'h00C;
  localparam logic [REG_AW-1:0] A_CMP_LO  = 12'h010;
  localparam logic [REG_AW-1:0] A_CMP_HI  = 12'h014;
  localparam logic [REG_AW-1:0] A_IDENT   = 12'hFCC;

  localparam int unsigned ST_EN  = 0;
  localparam int unsigned ST_WS0 = 1;
  localparam int unsigned ST_WS1 = 2;

  typedef struct packed {
    logic refresh;
    logic ctrl;
    logic off_lo;
    logic off_hi;
  } wr_strobe_t;
endpackage

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int unsigned     CNT_W    = 64,
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_INIT;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt2_regif.sv
module wdt2_regif
  import wdt2_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned OFF_W    = 48,
  parameter logic [31:0] ID_VALUE = 32'h0001_0A5B
) (
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic              bus_frame,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic              ctl_en,
  input  logic              st_ws0,
  input  logic              st_ws1,
  input  logic [OFF_W-1:0]  off_val,
  input  logic [CNT_W-1:0]  cmp_val,
  output wr_strobe_t        wr_stb,
  output logic [31:0]       rd_data
);
  logic        acc_ok;
  logic [63:0] cmp_ext;

  assign cmp_ext = 64'(cmp_val);
  assign acc_ok  = bus_req && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);

  always_comb begin
    wr_stb  = '0;
    rd_data = '0;
    if (acc_ok && bus_wr) begin
      if (!bus_frame) begin
        wr_stb.refresh = (bus_addr == A_REFRESH);
      end else begin
        case (bus_addr)
          A_CTRL:   wr_stb.ctrl   = 1'b1;
          A_OFF_LO: wr_stb.off_lo = 1'b1;
          A_OFF_HI: wr_stb.off_hi = 1'b1;
          default:  ;
        endcase
      end
    end
    if (acc_ok && !bus_wr) begin
      if (!bus_frame) begin
        if (bus_addr == A_IDENT) rd_data = ID_VALUE;
      end else begin
        case (bus_addr)
          A_CTRL: begin
            rd_data[ST_EN]  = ctl_en;
            rd_data[ST_WS0] = st_ws0;
            rd_data[ST_WS1] = st_ws1;
          end
          A_OFF_LO: rd_data = off_val[31:0];
          A_OFF_HI: rd_data = 32'(off_val[OFF_W-1:32]);
          A_CMP_LO: rd_data = cmp_ext[31:0];
          A_CMP_HI: rd_data = cmp_ext[63:32];
          A_IDENT:  rd_data = ID_VALUE;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
  import wdt2_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned OFF_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       wr_stb,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] cnt,
  output logic             ctl_en,
  output logic             st_ws0,
  output logic             st_ws1,
  output logic [OFF_W-1:0] off_val,
  output logic [CNT_W-1:0] cmp_val,
  output logic             irq_o,
  output logic             rstp_o
);
  localparam int unsigned HI_W = OFF_W - 32;

  logic             en_q, en_d, ws0_q, ws0_d, ws1_q, ws1_d, irq_q, irq_d;
  logic             rstp_q, rstp_d;
  logic [31:0]      lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             any_wr, hit, upd;

  assign any_wr = |wr_stb;
  assign hit    = en_q && (cnt >= cmp_q);
  assign upd    = rstp_q || any_wr || hit;

  always_comb begin
    en_d   = en_q;
    ws0_d  = ws0_q;
    ws1_d  = ws1_q;
    irq_d  = irq_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    cmp_d  = cmp_q;
    rstp_d = 1'b0;
    if (rstp_q) begin
      en_d  = 1'b0;
      ws0_d = 1'b0;
      ws1_d = 1'b0;
      irq_d = 1'b0;
      lo_d  = '0;
      hi_d  = '0;
      cmp_d = '0;
    end else if (any_wr) begin
      if (wr_stb.ctrl)   en_d = wdata[ST_EN];
      if (wr_stb.off_lo) lo_d = wdata;
      if (wr_stb.off_hi) hi_d = wdata[HI_W-1:0];
      ws0_d = 1'b0;
      ws1_d = 1'b0;
      irq_d = 1'b0;
      if (en_d) cmp_d = cnt + CNT_W'({hi_d, lo_d});
    end else if (hit) begin
      if (!ws0_q) begin
        ws0_d = 1'b1;
        irq_d = 1'b1;
        cmp_d = cnt + CNT_W'({hi_q, lo_q});
      end else begin
        ws1_d  = 1'b1;
        rstp_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
      irq_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
      cmp_q <= '0;
    end else if (upd) begin
      en_q  <= en_d;
      ws0_q <= ws0_d;
      ws1_q <= ws1_d;
      irq_q <= irq_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      cmp_q <= cmp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rstp_q <= 1'b0;
    else        rstp_q <= rstp_d;
  end

  assign ctl_en  = en_q;
  assign st_ws0  = ws0_q;
  assign st_ws1  = ws1_q;
  assign off_val = {hi_q, lo_q};
  assign cmp_val = cmp_q;
  assign irq_o   = irq_q;
  assign rstp_o  = rstp_q;
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
  import wdt2_pkg::*;
#(
  parameter int unsigned      CNT_W    = 64,
  parameter int unsigned      OFF_W    = 48,
  parameter logic [CNT_W-1:0] CNT_INIT = '0,
  parameter logic [31:0]      ID_VALUE = 32'h0001_0A5B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic        bus_frame,
  input  logic [11:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wd_irq,
  output logic        wd_rst
);
  logic [CNT_W-1:0] sys_cnt;
  logic [CNT_W-1:0] cmp_val;
  logic [OFF_W-1:0] off_val;
  logic             ctl_en, st_ws0, st_ws1;
  wr_strobe_t       wr_stb;

  wdt2_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) cnt_i (
    .clk(clk), .rst_n(rst_n), .cnt_o(sys_cnt)
  );

  wdt2_regif #(.CNT_W(CNT_W), .OFF_W(OFF_W), .ID_VALUE(ID_VALUE)) regif_i (
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_be(bus_be),
    .ctl_en(ctl_en), .st_ws0(st_ws0), .st_ws1(st_ws1),
    .off_val(off_val), .cmp_val(cmp_val),
    .wr_stb(wr_stb), .rd_data(bus_rdata)
  );

  wdt2_core #(.CNT_W(CNT_W), .OFF_W(OFF_W)) core_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wdata(bus_wdata),
    .cnt(sys_cnt), .ctl_en(ctl_en), .st_ws0(st_ws0), .st_ws1(st_ws1),
    .off_val(off_val), .cmp_val(cmp_val), .irq_o(wd_irq), .rstp_o(wd_rst)
  );
endmodule

// File: rtl/wdt2_checks.sv
module wdt2_checks
  import wdt2_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_wr,
  input logic        bus_frame,
  input logic [11:0] bus_addr,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_rdata,
  input logic        wd_irq,
  input logic        wd_rst,
  input logic        en,
  input logic        ws0,
  input logic        ws1,
  input wr_strobe_t  wr_stb
);
  a_r8_rst_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);

  a_r8_regs_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> (!en && !ws0 && !ws1 && !wd_irq));

  a_r8_rst_needs_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst) |-> $past(ws0));

  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_irq) |-> $past(en));

  a_r7_irq_implies_ws0: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> ws0);

  a_r6_write_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_stb) && !wd_rst) |=> (!ws0 && !ws1 && !wd_irq));

  a_r4_refresh_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && !bus_frame && bus_addr == A_REFRESH && bus_be == 4'hF)
      |-> bus_rdata == 32'h0);
endmodule

bind wdt2_top wdt2_checks chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_frame(bus_frame), .bus_addr(bus_addr), .bus_be(bus_be),
  .bus_rdata(bus_rdata), .wd_irq(wd_irq), .wd_rst(wd_rst),
  .en(ctl_en), .ws0(st_ws0), .ws1(st_ws1), .wr_stb(wr_stb)
);

// File: tb/wdt2_top_tb_top.sv
module wdt2_top_tb_top;
  localparam logic [63:0] TB_CNT_INIT = 64'h0000_0000_FFFF_FFF0;
  localparam logic [31:0] TB_ID       = 32'h0001_0A5B;
  localparam int          OFF         = 20;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk, rst_n, bus_req, bus_wr, bus_frame;
  logic [11:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wd_irq, wd_rst;

  int n_chk, n_fail, rst_pulses;
  bit done;
  sb_item_t sb_q[$];

  wdt2_top #(.CNT_INIT(TB_CNT_INIT), .ID_VALUE(TB_ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_frame(bus_frame), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_irq(wd_irq), .wd_rst(wd_rst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wd_rst) rst_pulses++;
    if (bus_req && !bus_wr && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.tag, 64'(bus_rdata), 64'(it.exp));
    end
  end

  task automatic wr(input logic fr, input logic [11:0] a, input logic [31:0] d,
                    input logic [3:0] be = 4'hF);
    bus_req = 1'b1; bus_wr = 1'b1; bus_frame = fr; bus_addr = a;
    bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic fr, input logic [11:0] a, input logic [31:0] exp,
                    input string tag, input logic [3:0] be = 4'hF);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_req = 1'b1; bus_wr = 1'b0; bus_frame = fr; bus_addr = a; bus_be = be;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic peek(input logic fr, input logic [11:0] a, output logic [31:0] v);
    bus_req = 1'b1; bus_wr = 1'b0; bus_frame = fr; bus_addr = a; bus_be = 4'hF;
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a_lo, a_hi;
    logic [63:0] a_cmp, b_cmp;
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_frame = 1'b0;
    bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    cyc(1);

    chk("R8 reset irq", 64'(wd_irq), 0);
    chk("R8 reset rst", 64'(wd_rst), 0);
    rd(1, 12'h000, 32'h0, "R5 reset status");
    rd(0, 12'hFCC, TB_ID, "R10 ident refresh frame");
    rd(1, 12'hFCC, TB_ID, "R10 ident control frame");

    // R1: offset composition and upper-word masking
    wr(1, 12'h008, 32'hA5A5_0000);
    wr(1, 12'h00C, 32'hFFFF_0003);
    rd(1, 12'h008, 32'hA5A5_0000, "R1 offset low word");
    rd(1, 12'h00C, 32'h0000_0003, "R1 offset high word masked");
    wr(1, 12'h00C, 32'h0);
    wr(1, 12'h008, OFF);

    // R9: partial, unaligned and undefined accesses ignored
    wr(1, 12'h008, 32'd99, 4'b0011);
    rd(1, 12'h008, OFF, "R9 partial write ignored");
    wr(1, 12'h000, 32'h1, 4'b0001);
    rd(1, 12'h000, 32'h0, "R9 partial ctrl write ignored");
    rd(1, 12'h009, 32'h0, "R9 unaligned read zero");
    rd(1, 12'h020, 32'h0, "R9 undefined read zero");
    rd(1, 12'h008, 32'h0, "R9 partial read zero", 4'b0111);

    // R11: disabled, nothing expires
    cyc(60);
    chk("R11 no irq while disabled", 64'(wd_irq), 0);

    // R5 / R2 / R7 / R8 : full two-stage expiry
    wr(1, 12'h000, 32'hFFFF_FFFF);                       // edge e0
    rd(1, 12'h000, 32'h1, "R5 only enable kept");        // e1
    peek(1, 12'h010, a_lo);                              // e2
    peek(1, 12'h014, a_hi);                              // e3
    a_cmp = {a_hi, a_lo};
    chk("R2 compare high word after carry", 64'(a_hi), 1);
    cyc(OFF - 4);
    chk("R2 irq not before offset", 64'(wd_irq), 0);
    cyc(1);
    chk("R2 irq at offset edge", 64'(wd_irq), 1);
    b_cmp = a_cmp + 64'(OFF);
    rd(1, 12'h000, 32'h3, "R7 first-stage flag");        // e21
    rd(1, 12'h010, b_cmp[31:0], "R7 rearm compare low"); // e22
    rd(1, 12'h014, b_cmp[63:32], "R7 rearm compare high"); // e23
    chk("R7 irq level held", 64'(wd_irq), 1);
    cyc(OFF - 4);
    chk("R8 no reset before second window", 64'(wd_rst), 0);
    cyc(1);
    chk("R8 reset pulse at second expiry", 64'(wd_rst), 1);
    rd(1, 12'h000, 32'h7, "R8 second-stage flag");        // e41
    chk("R8 reset pulse one cycle", 64'(wd_rst), 0);
    chk("R8 irq cleared by self reset", 64'(wd_irq), 0);
    rd(1, 12'h000, 32'h0, "R8 status reset");
    rd(1, 12'h008, 32'h0, "R8 offset reset");
    rd(1, 12'h014, 32'h0, "R8 compare reset");

    // R3: refresh-frame write clears and re-arms
    wr(1, 12'h008, OFF);
    wr(1, 12'h000, 32'h1);
    cyc(OFF - 1);
    chk("R3 setup irq low", 64'(wd_irq), 0);
    cyc(1);
    chk("R3 setup irq high", 64'(wd_irq), 1);
    wr(0, 12'h000, 32'hDEAD_BEEF);                       // f0
    chk("R3 refresh drops irq", 64'(wd_irq), 0);
    rd(1, 12'h000, 32'h1, "R3 refresh clears flags");    // f1
    cyc(OFF - 2);
    chk("R3 re-armed window not early", 64'(wd_irq), 0);
    cyc(1);
    chk("R3 re-armed window expires", 64'(wd_irq), 1);

    // R4: refresh register read has no effect
    rd(0, 12'h000, 32'h0, "R4 refresh read zero");
    chk("R4 irq untouched", 64'(wd_irq), 1);
    rd(1, 12'h000, 32'h3, "R4 flags untouched");

    // R6: offset write acts as refresh
    wr(1, 12'h00C, 32'h0);
    chk("R6 offset write drops irq", 64'(wd_irq), 0);
    rd(1, 12'h000, 32'h1, "R6 offset write clears flags");
    wr(1, 12'h008, 32'd50);
    cyc(OFF + 5);
    chk("R6 new offset used", 64'(wd_irq), 0);

    // R11: disable then wait well past any window
    wr(1, 12'h000, 32'h0);
    cyc(120);
    chk("R11 disabled irq", 64'(wd_irq), 0);
    chk("R11 single reset pulse in run", 64'(rst_pulses), 1);

    cyc(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule